// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the memory-mapped register file that sits in front of a colour LCD pixel pipeline. A 32-bit bus master reads and writes word registers inside a 4 KB window. Word offsets 0 to 3 hold four panel timing words and offsets 4 and 5 hold the upper and lower frame base addresses. The next two words are control and interrupt mask, in an order that depends on the layout. After them come raw status, masked status and a write-one-to-clear word. The window also contains a 128-word palette area and a read-only identification area of eight words.

From the stored state the block derives the panel geometry, a display-active flag, a pixel-depth code and three pixel-ordering flags, all for the downstream pixel path. External event inputs set status bits, and a single interrupt line reports any status bit that is also enabled in the mask. The parameter `NEW_LAYOUT` picks between the two register layouts and their identification bytes. The bus has no wait states: read data is combinational from the word address, and writes commit on the clock edge.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every register, status bit and palette word reads as zero, `disp_on_o`, `irq_o` and `err_o` are low, and the geometry outputs show width 16 and height 1.
- R2: Byte offsets 0x000–0x00C (four timing words) and 0x010 / 0x014 (upper and lower frame base) store all 32 bits written and read them back.
- R3: `panel_width_o` equals ((timing0 & 0xFC) + 4) * 4 and `panel_height_o` equals (timing1 & 0x3FF) + 1. Both change only in the cycle after a write to the matching timing word.
- R4: In the control word, bit 0 is enable and bit 11 is power, and `disp_on_o` is high only when both are set. Bits [3:1] drive `pix_depth_o`, bit 8 drives `bgr_o`, bit 9 drives `be_byte_o` and bit 10 drives `be_pix_o`.
- R5: With `NEW_LAYOUT`=1, offset 0x018 is the interrupt mask and 0x01C is control. With `NEW_LAYOUT`=0 the two are exchanged.
- R6: Offset 0x020 reads the raw status and 0x024 reads raw status AND mask, both zero-extended from `IRQ_W` bits. The mask stores only its low `IRQ_W` bits. `irq_o` is high whenever any masked status bit is set.
- R7: A write to offset 0x028 clears every status bit whose data bit is 1. An `evt_i` bit that is high in the same cycle sets its status bit, and the set wins over the clear.
- R8: Offsets 0x200–0x3FC address 128 palette words at index (offset − 0x200) >> 2. Each word stores 32 bits.
- R9: Offsets 0xFE0–0xFFC are read-only and return one identification byte each, in order. With `NEW_LAYOUT`=1 the bytes are 0x11,0x11,0x24,0x00,0x0D,0xF0,0x05,0xB1. With `NEW_LAYOUT`=0 they are 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1.
- R10: Some accesses are unmapped: a read of offset 0x028, a write to 0x020, 0x024 or the identification area, and any access to an offset outside all listed areas. An unmapped read returns zero and an unmapped write changes nothing. Each unmapped access raises `err_o` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| evt_i | input | IRQ_W | Interrupt event inputs, each sets its status bit |
| irq_o | output | 1 | OR of masked status bits |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| panel_width_o | output | 11 | Panel width in pixels |
| panel_height_o | output | 11 | Panel height in lines |
| disp_on_o | output | 1 | Enable and power both set |
| pix_depth_o | output | 3 | Pixel depth code |
| bgr_o | output | 1 | BGR component order |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |

## Verification
A bus write to the clear word can land in the same clock edge as an event pulse on `evt_i`. The bench provokes this by driving a clear of all status bits while holding one event bit high for that single cycle. It then reads the raw status word back and expects only the event bit to remain, with `irq_o` following the mask. A checker assertion also confirms, on every edge, that each event bit from the previous cycle is now set in the status, whatever the bus did.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

   localparam int WIN_ADDR_W = 12;
   localparam int WORD_AW    = WIN_ADDR_W - 2;

   // word indices that do not move between layouts
   localparam logic [3:0] IDX_BASE_UP = 4'd4;
   localparam logic [3:0] IDX_BASE_LO = 4'd5;
   localparam logic [3:0] IDX_RAW     = 4'd8;
   localparam logic [3:0] IDX_MSKD    = 4'd9;
   localparam logic [3:0] IDX_CLR     = 4'd10;

   typedef enum logic [1:0] {
      RGN_NONE,
      RGN_REG,
      RGN_PAL,
      RGN_ID
   } region_e;

   function automatic logic [7:0] id_byte_new(input logic [2:0] k);
      case (k)
         3'd0: return 8'h11;
         3'd1: return 8'h11;
         3'd2: return 8'h24;
         3'd3: return 8'h00;
         3'd4: return 8'h0D;
         3'd5: return 8'hF0;
         3'd6: return 8'h05;
         default: return 8'hB1;
      endcase
   endfunction

   function automatic logic [7:0] id_byte_old(input logic [2:0] k);
      case (k)
         3'd0: return 8'h10;
         3'd1: return 8'h11;
         3'd2: return 8'h04;
         3'd3: return 8'h00;
         3'd4: return 8'h0D;
         3'd5: return 8'hF0;
         3'd6: return 8'h05;
         default: return 8'hB1;
      endcase
   endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
   import lcdc_pkg::*;
(
   input  logic [WORD_AW-1:0] waddr,
   output region_e            region,
   output logic [3:0]         reg_idx,
   output logic [6:0]         pal_idx,
   output logic [2:0]         id_idx
);

   always_comb begin
      region = RGN_NONE;
      if (waddr[9:4] == 6'd0 && waddr[3:0] <= IDX_CLR) begin
         region = RGN_REG;
      end else if (waddr[9:7] == 3'b001) begin
         region = RGN_PAL;
      end else if (waddr[9:3] == 7'h7F) begin
         region = RGN_ID;
      end
   end

   assign reg_idx = waddr[3:0];
   assign pal_idx = waddr[6:0];
   assign id_idx  = waddr[2:0];

endmodule

// File: rtl/lcdc_palette.sv
module lcdc_palette #(
   parameter int WORDS  = 128,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] idx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[idx] <= wdata;
      end
   end

   assign rdata = mem_q[idx];

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wd,
   input  logic         clr_we,
   input  logic [W-1:0] clr_wd,
   input  logic [W-1:0] evt_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);

   logic [W-1:0] status_q, mask_q, clr_vec;

   assign clr_vec = clr_we ? clr_wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr_vec) | evt_i;
         if (mask_we) mask_q <= mask_wd;
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign irq_o    = |(status_q & mask_q);

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom (
   input  logic [5:0]  ppl_field,
   input  logic [9:0]  lpl_field,
   output logic [10:0] width_px,
   output logic [10:0] height_ln
);

   logic [6:0] groups16;

   // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
   assign groups16  = {1'b0, ppl_field} + 7'd1;
   assign width_px  = {groups16, 4'b0000};
   assign height_ln = {1'b0, lpl_field} + 11'd1;

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
   import lcdc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IRQ_W      = 5,
   parameter int PAL_WORDS  = 128,
   parameter bit NEW_LAYOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [11:2]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [IRQ_W-1:0]  evt_i,
   output logic              irq_o,
   output logic              err_o,
   output logic [10:0]       panel_width_o,
   output logic [10:0]       panel_height_o,
   output logic              disp_on_o,
   output logic [2:0]        pix_depth_o,
   output logic              bgr_o,
   output logic              be_byte_o,
   output logic              be_pix_o
);

   localparam logic [3:0] IDX_MASK = NEW_LAYOUT ? 4'd6 : 4'd7;
   localparam logic [3:0] IDX_CTRL = NEW_LAYOUT ? 4'd7 : 4'd6;
   localparam int         PAL_AW   = $clog2(PAL_WORDS);
   localparam int         N_TIM    = 4;

   initial begin
      assert (DATA_W == 32) else $fatal(1, "lcdc_regbank: DATA_W must be 32");
      assert (IRQ_W >= 1 && IRQ_W < DATA_W) else $fatal(1, "lcdc_regbank: IRQ_W out of range");
      assert (PAL_WORDS == 128) else $fatal(1, "lcdc_regbank: palette window holds 128 words");
   end

   region_e          region;
   logic [3:0]       reg_idx;
   logic [PAL_AW-1:0] pal_idx;
   logic [2:0]       id_idx;

   lcdc_addr_dec u_dec (
      .waddr   (bus_addr),
      .region  (region),
      .reg_idx (reg_idx),
      .pal_idx (pal_idx),
      .id_idx  (id_idx)
   );

   logic acc_wr, acc_rd;
   assign acc_wr = bus_sel &  bus_wr;
   assign acc_rd = bus_sel & ~bus_wr;

   logic in_reg;
   assign in_reg = (region == RGN_REG);

   // ---------------- timing, base and control words ----------------
   logic [DATA_W-1:0] tim_q [N_TIM];
   logic [DATA_W-1:0] base_up_q, base_lo_q, ctrl_q;

   for (genvar t = 0; t < N_TIM; t++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      tim_q[t] <= '0;
         else if (acc_wr && in_reg && reg_idx == 4'(t))   tim_q[t] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_up_q <= '0;
         base_lo_q <= '0;
         ctrl_q    <= '0;
      end else if (acc_wr && in_reg) begin
         if (reg_idx == IDX_BASE_UP) base_up_q <= bus_wdata;
         if (reg_idx == IDX_BASE_LO) base_lo_q <= bus_wdata;
         if (reg_idx == IDX_CTRL)    ctrl_q    <= bus_wdata;
      end
   end

   // ---------------- interrupt status and mask ----------------
   logic [IRQ_W-1:0] irq_status, irq_mask;

   lcdc_irq #(.W(IRQ_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (acc_wr && in_reg && reg_idx == IDX_MASK),
      .mask_wd  (bus_wdata[IRQ_W-1:0]),
      .clr_we   (acc_wr && in_reg && reg_idx == IDX_CLR),
      .clr_wd   (bus_wdata[IRQ_W-1:0]),
      .evt_i    (evt_i),
      .status_o (irq_status),
      .mask_o   (irq_mask),
      .irq_o    (irq_o)
   );

   // ---------------- palette ----------------
   logic [DATA_W-1:0] pal_rdata;

   lcdc_palette #(.WORDS(PAL_WORDS), .DATA_W(DATA_W)) u_pal (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_wr && region == RGN_PAL),
      .idx   (pal_idx),
      .wdata (bus_wdata),
      .rdata (pal_rdata)
   );

   // ---------------- identification bytes ----------------
   logic [7:0] id_val;

   if (NEW_LAYOUT) begin : g_id_new
      assign id_val = id_byte_new(id_idx);
   end else begin : g_id_old
      assign id_val = id_byte_old(id_idx);
   end

   // ---------------- geometry and pixel-path controls ----------------
   lcdc_geom u_geom (
      .ppl_field (tim_q[0][7:2]),
      .lpl_field (tim_q[1][9:0]),
      .width_px  (panel_width_o),
      .height_ln (panel_height_o)
   );

   assign disp_on_o   = ctrl_q[0] & ctrl_q[11];
   assign pix_depth_o = ctrl_q[3:1];
   assign bgr_o       = ctrl_q[8];
   assign be_byte_o   = ctrl_q[9];
   assign be_pix_o    = ctrl_q[10];

   // ---------------- read mux and access legality ----------------
   logic [DATA_W-1:0] reg_rdata;
   logic              rd_legal, wr_legal;

   always_comb begin
      reg_rdata = '0;
      if (reg_idx < 4'(N_TIM))          reg_rdata = tim_q[reg_idx[1:0]];
      else if (reg_idx == IDX_BASE_UP)  reg_rdata = base_up_q;
      else if (reg_idx == IDX_BASE_LO)  reg_rdata = base_lo_q;
      else if (reg_idx == IDX_MASK)     reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_mask};
      else if (reg_idx == IDX_CTRL)     reg_rdata = ctrl_q;
      else if (reg_idx == IDX_RAW)      reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_status};
      else if (reg_idx == IDX_MSKD)     reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_status & irq_mask};
   end

   always_comb begin
      rd_legal = 1'b0;
      wr_legal = 1'b0;
      unique case (region)
         RGN_REG: begin
            rd_legal = (reg_idx != IDX_CLR);
            wr_legal = (reg_idx != IDX_RAW) && (reg_idx != IDX_MSKD);
         end
         RGN_PAL: begin
            rd_legal = 1'b1;
            wr_legal = 1'b1;
         end
         RGN_ID:  rd_legal = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      bus_rdata = '0;
      if (acc_rd && rd_legal) begin
         case (region)
            RGN_REG: bus_rdata = reg_rdata;
            RGN_PAL: bus_rdata = pal_rdata;
            RGN_ID:  bus_rdata = {{(DATA_W-8){1'b0}}, id_val};
            default: bus_rdata = '0;
         endcase
      end
   end

   logic err_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (acc_rd && !rd_legal) || (acc_wr && !wr_legal);
   end
   assign err_o = err_q;

endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
   parameter int IRQ_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [11:2]       bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [IRQ_W-1:0]  evt_i,
   input logic [IRQ_W-1:0]  status_q,
   input logic              err_o,
   input logic              disp_on_o,
   input logic [10:0]       panel_width_o
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic [IRQ_W-1:0] clr_only;
   assign clr_only = (bus_sel && bus_wr && bus_addr == 10'd10)
                   ? (bus_wdata[IRQ_W-1:0] & ~evt_i) : '0;

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ((status_q & $past(evt_i)) == $past(evt_i)))
      else $error("event bit not captured in status"); // R7

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ((status_q & $past(clr_only)) == '0))
      else $error("cleared status bit still set"); // R7

   AST_DISP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (disp_on_o != $past(disp_on_o)) |-> $past(bus_sel && bus_wr))
      else $error("display flag moved without a write"); // R4

   AST_WIDTH_BY_TIM0: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (panel_width_o != $past(panel_width_o)) |-> $past(bus_sel && bus_wr && bus_addr == 10'd0))
      else $error("width moved without a timing0 write"); // R3

   AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      err_o |-> $past(bus_sel))
      else $error("error pulse without an access"); // R10

endmodule

bind lcdc_regbank lcdc_regbank_chk #(.IRQ_W(IRQ_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_sel       (bus_sel),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .evt_i         (evt_i),
   .status_q      (irq_status),
   .err_o         (err_o),
   .disp_on_o     (disp_on_o),
   .panel_width_o (panel_width_o)
);

// File: tb/lcdc_regbank_tb_top.sv
`timescale 1ns/1ps
module lcdc_regbank_tb_top;

   localparam int IRQ_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [11:2]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [IRQ_W-1:0]  evt = '0;

   logic [31:0] rdata_n, rdata_o;
   logic        irq_n, irq_o_old, err_n, err_old;
   logic [10:0] w_n, h_n, w_o, h_o;
   logic        on_n, on_o, bgr_n, bgr_o_old, beb_n, beb_o_old, bep_n, bep_o_old;
   logic [2:0]  dep_n, dep_o;

   always #2.5 clk = ~clk;

   lcdc_regbank #(.IRQ_W(IRQ_W), .NEW_LAYOUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
      .evt_i(evt), .irq_o(irq_n), .err_o(err_n),
      .panel_width_o(w_n), .panel_height_o(h_n), .disp_on_o(on_n),
      .pix_depth_o(dep_n), .bgr_o(bgr_n), .be_byte_o(beb_n), .be_pix_o(bep_n)
   );

   lcdc_regbank #(.IRQ_W(IRQ_W), .NEW_LAYOUT(1'b0)) dut_old_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_o),
      .evt_i(evt), .irq_o(irq_o_old), .err_o(err_old),
      .panel_width_o(w_o), .panel_height_o(h_o), .disp_on_o(on_o),
      .pix_depth_o(dep_o), .bgr_o(bgr_o_old), .be_byte_o(beb_o_old), .be_pix_o(bep_o_old)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] rd_new, rd_old;
   logic        last_err;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] off, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off[11:2]; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1 last_err = err_n;
   endtask

   task automatic bus_read(input logic [11:0] off);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off[11:2];
      #1 rd_new = rdata_n; rd_old = rdata_o;
      @(negedge clk);
      bus_sel = 1'b0;
      #1 last_err = err_n;
   endtask

   // {offset, write data, expected read-back} for the new layout
   localparam int NVEC = 10;
   localparam logic [75:0] VEC [NVEC] = '{
      {12'h000, 32'hDEADBEEF, 32'hDEADBEEF},   // R2 timing0
      {12'h004, 32'h12345678, 32'h12345678},   // R2 timing1
      {12'h008, 32'hA5A5A5A5, 32'hA5A5A5A5},   // R2 timing2
      {12'h00C, 32'h0F0F0F0F, 32'h0F0F0F0F},   // R2 timing3
      {12'h010, 32'h80001000, 32'h80001000},   // R2 upper base
      {12'h014, 32'h80042000, 32'h80042000},   // R2 lower base
      {12'h200, 32'hCAFEF00D, 32'hCAFEF00D},   // R8 first palette word
      {12'h3FC, 32'h01234567, 32'h01234567},   // R8 last palette word
      {12'h0B0, 32'hFFFFFFFF, 32'h00000000},   // R10 unmapped word
      {12'hFE0, 32'h000000FF, 32'h00000011}    // R9 id area ignores writes
   };

   initial begin : watchdog
      #(200000 * 5);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      check("R1 disp_on", {31'd0, on_n}, 32'd0);
      check("R1 irq", {31'd0, irq_n}, 32'd0);
      check("R1 err", {31'd0, err_n}, 32'd0);
      check("R1 width", {21'd0, w_n}, 32'd16);
      check("R1 height", {21'd0, h_n}, 32'd1);
      bus_read(12'h01C); check("R1 ctrl", rd_new, 32'd0);
      bus_read(12'h020); check("R1 status", rd_new, 32'd0);
      bus_read(12'h280); check("R1 palette", rd_new, 32'd0);

      // table walk: write, read back
      for (int i = 0; i < NVEC; i++) begin
         bus_write(VEC[i][75:64], VEC[i][63:32]);
         bus_read(VEC[i][75:64]);
         check("R2/R8/R9/R10 table", rd_new, VEC[i][31:0]);
      end

      // R3 geometry
      bus_write(12'h000, 32'h000000A8);
      bus_write(12'h004, 32'h000001DF);
      check("R3 width 688", {21'd0, w_n}, 32'd688);
      check("R3 height 480", {21'd0, h_n}, 32'd480);
      bus_write(12'h000, 32'hFFFFFFFF);
      bus_write(12'h004, 32'hFFFFFFFF);
      check("R3 width max", {21'd0, w_n}, 32'd1024);
      check("R3 height max", {21'd0, h_n}, 32'd1024);

      // R4 control word at 0x01C (new layout)
      bus_write(12'h01C, 32'h00000F0B);
      check("R4 disp_on", {31'd0, on_n}, 32'd1);
      check("R4 depth", {29'd0, dep_n}, 32'd5);
      check("R4 order flags", {29'd0, bep_n, beb_n, bgr_n}, 32'd7);
      bus_write(12'h01C, 32'h00000701);
      check("R4 no power", {31'd0, on_n}, 32'd0);
      bus_write(12'h01C, 32'h00000800);
      check("R4 no enable", {31'd0, on_n}, 32'd0);
      check("R4 flags cleared", {29'd0, bep_n, beb_n, bgr_n}, 32'd0);

      // R5 layout swap: 0x018 is mask (new) / control (old)
      bus_write(12'h018, 32'h00000801);
      check("R5 new disp stays off", {31'd0, on_n}, 32'd0);
      check("R5 old disp on", {31'd0, on_o}, 32'd1);
      bus_read(12'h018);
      check("R5 new mask low bits", rd_new, 32'd1);
      check("R5 old control", rd_old, 32'h00000801);

      // R9 identification per variant
      bus_read(12'hFE0);
      check("R9 old byte0", rd_old, 32'h10);
      bus_read(12'hFE8);
      check("R9 new byte2", rd_new, 32'h24);
      check("R9 old byte2", rd_old, 32'h04);
      bus_read(12'hFFC);
      check("R9 last byte", rd_new, 32'hB1);

      // R6 status and mask
      bus_write(12'h018, 32'h00000005);
      @(negedge clk); evt = 5'b00011;
      @(negedge clk); evt = '0;
      bus_read(12'h020); check("R6 raw", rd_new, 32'h3);
      bus_read(12'h024); check("R6 masked", rd_new, 32'h1);
      check("R6 irq high", {31'd0, irq_n}, 32'd1);
      bus_write(12'h028, 32'h00000001);
      bus_read(12'h020); check("R7 clear bit0", rd_new, 32'h2);
      check("R6 irq low", {31'd0, irq_n}, 32'd0);

      // R7 set beats clear in the same cycle
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'd10; bus_wdata = 32'h1F; evt = 5'b00100;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; evt = '0;
      bus_read(12'h020); check("R7 set wins", rd_new, 32'h4);
      check("R7 irq from winner", {31'd0, irq_n}, 32'd1);
      bus_write(12'h028, 32'h00000004);
      bus_read(12'h020); check("R7 final clear", rd_new, 32'h0);

      // R10 unmapped accesses
      bus_read(12'h0B0);
      check("R10 unmapped read data", rd_new, 32'h0);
      check("R10 unmapped read err", {31'd0, last_err}, 32'd1);
      bus_read(12'h028);
      check("R10 clear word read err", {31'd0, last_err}, 32'd1);
      bus_write(12'h020, 32'h1F);
      check("R10 status write err", {31'd0, last_err}, 32'd1);
      bus_read(12'h020); check("R10 status unchanged", rd_new, 32'h0);
      check("R10 legal read no err", {31'd0, last_err}, 32'd0);
      @(negedge clk);
      check("R10 err one cycle", {31'd0, err_n}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule